// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Error-Signal Retry

This block sends bytes over a single half-duplex, open-drain serial line of the kind used by contact smart cards. Software or a DMA engine writes bytes into a small transmit buffer. The block frames each byte as one character: a low start bit, eight data bits sent least significant bit first, a parity bit, and a stop period during which the line is released. It only ever pulls the line low. A `1` level, the stop period and the idle state all come from an external pull-up. Bit timing comes from an external baud generator. That generator supplies a boundary strobe, which stands for the falling edge of the bit clock, and a mid-bit strobe.

In the character protocol with receiver error signalling, the receiver pulls the line low during the stop period to reject a character whose parity was wrong. The transmitter samples the line in the middle of that period. If the line is low, it keeps the line released for two more bit periods and then sends the same byte again, up to a programmed number of retries. A byte that is still rejected after its last retry is dropped, and a sticky error flag is raised. In the block protocol, the line is not examined and nothing is ever resent. After each character the block can insert a programmable number of idle guard periods. A queued byte then starts without any software action.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, and whenever `busy` is 0, `tx_oe` is 0 (line released). After reset, `dma_req` is 1 and `buf_full`, `empty_irq` and `err_flag` are 0.
- R2: `tx_oe`=1 pulls the line low. On the first `bit_tick` at which a byte is buffered, the byte is loaded and the start bit (line low) begins. Each following `bit_tick` moves to the next bit: data bits 0 to 7 in that order, then the parity bit, then one released stop period. `tx_oe` changes only in the cycle after a `bit_tick`.
- R3: With `cfg_odd`=0 the parity bit equals the XOR of the eight data bits (even parity). With `cfg_odd`=1 it is the inverse of that XOR (odd parity).
- R4: With `cfg_guard`=0 and a byte waiting, the next start bit follows the stop period directly, so consecutive start bits are 11 bit periods apart.
- R5: With `cfg_guard`=G>0, the line stays released for G extra bit periods after the stop period, so consecutive start bits are 11+G bit periods apart.
- R6: The buffer holds DEPTH bytes (2 by default). `buf_full` is 1 when it is full, and a write while it is full is discarded.
- R7: When `cfg_t0`=1, `line_in` is sampled at the `sample_tick` inside the stop period. If it is low and retries remain, the same byte is sent again with its start bit 13 bit periods after the previous start bit.
- R8: Each byte gets `cfg_retry` retransmissions. If the byte is still rejected after the last one (or at once when `cfg_retry`=0), it is dropped and `err_flag` is set. `err_flag` stays set until `err_clr`.
- R9: When `cfg_t0`=0, a low `line_in` during the stop period has no effect: the byte is sent once and `err_flag` stays 0.
- R10: `busy` is 1 from the start bit through the stop period, including the retransmission wait. It is 0 during guard periods and when idle. It changes only in the cycle after a `bit_tick`.
- R11: `empty_irq` is a one-cycle pulse raised when a load takes the last byte out of the buffer. `dma_req` is 1 whenever the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle strobe at each bit boundary |
| sample_tick | input | 1 | One-cycle strobe at the middle of each bit period |
| wr_en | input | 1 | Write strobe into the transmit buffer |
| wr_data | input | 8 | Byte to enqueue |
| cfg_t0 | input | 1 | 1: check for the receiver error signal and retry; 0: block protocol |
| cfg_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_guard | input | GUARD_W | Extra idle bit periods after each stop period |
| cfg_retry | input | RETRY_W | Retransmissions allowed per byte |
| err_clr | input | 1 | Clears the sticky error flag |
| line_in | input | 1 | Sampled level of the shared line |
| tx_oe | output | 1 | 1 pulls the line low, 0 releases it |
| busy | output | 1 | Character in progress |
| buf_full | output | 1 | Transmit buffer full |
| empty_irq | output | 1 | Pulse: last buffered byte taken |
| dma_req | output | 1 | Level: buffer empty, more data wanted |
| err_flag | output | 1 | Sticky: a byte was dropped after its retries |

## Verification
The hardest state to reach is exhaustion of the retry budget. Reaching it needs the line pulled low in exactly the middle of the stop period, once for every transmission of the same byte. The bench contains a small receiver model that follows the released line bit by bit. From a per-test budget, it pulls the line low from the second half of the parity bit until just after the mid-stop strobe. One rejected attempt, repeated rejection through the last retry, a zero retry count, and the same disturbance in block-protocol mode can each be set up this way. The bench measures the spacing between start bits to confirm the two-period wait before a resend.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_SHIFT = 3'd2,
    ST_STOP  = 3'd3,
    ST_WAIT  = 3'd4,
    ST_GUARD = 3'd5
  } tx_state_e;

  // Released bit periods between a rejected stop period and the resend.
  localparam int unsigned NACK_WAIT_PERIODS = 2;

  // Index of the parity bit within the shift phase (0..7 are data bits).
  localparam int unsigned PARITY_IDX = 8;

endpackage

// File: rtl/sc_tx_rst_sync.sv
module sc_tx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sc_tx_parity.sv
module sc_tx_parity #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] din,
  input  logic         odd,
  output logic         par
);

  logic [W:0] chain;

  assign chain[0] = odd;

  for (genvar i = 0; i < W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ din[i];
  end

  assign par = chain[W];

endmodule

// File: rtl/sc_tx_fifo.sv
module sc_tx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          avail,
  output logic          full,
  output logic          drained
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          drained_q, drained_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign avail   = (cnt_q != '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && avail;

  always_comb begin
    wptr_d    = wptr_q;
    rptr_d    = rptr_q;
    cnt_d     = cnt_q;
    drained_d = pop_ok && !push_ok && (cnt_q == CW'(1));
    if (push_ok) begin
      wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    end
    if (pop_ok) begin
      rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    end
    if (push_ok && !pop_ok) begin
      cnt_d = cnt_q + CW'(1);
    end else if (pop_ok && !push_ok) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      drained_q <= 1'b0;
    end else begin
      wptr_q    <= wptr_d;
      rptr_q    <= rptr_d;
      cnt_q     <= cnt_d;
      drained_q <= drained_d;
    end
  end

  // Storage carries no reset; only written entries are ever read.
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wptr_q] <= push_data;
    end
  end

  assign head    = mem[rptr_q];
  assign drained = drained_q;

endmodule

// File: rtl/sc_tx_sequencer.sv
module sc_tx_sequencer
  import sc_tx_pkg::*;
#(
  parameter int unsigned GW = 4,
  parameter int unsigned RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          sample_tick,
  input  logic          line_in,
  input  logic          cfg_t0,
  input  logic [GW-1:0] cfg_guard,
  input  logic [RW-1:0] cfg_retry,
  input  logic          err_clr,
  input  logic          buf_avail,
  input  logic [7:0]    buf_data,
  input  logic          buf_par,
  output logic          pop,
  output logic          tx_oe,
  output logic          busy,
  output logic          err_flag
);

  localparam int unsigned CNTW = (GW > 2) ? GW : 2;

  tx_state_e     state_q, state_d;
  logic [3:0]    idx_q, idx_d;
  logic [7:0]    byte_q, byte_d;
  logic          par_q, par_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] retry_q, retry_d;
  logic          nack_q, nack_d;
  logic          err_q, err_d;
  logic          load, finish, err_set;

  // Next-state process
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    byte_d  = byte_q;
    par_d   = par_q;
    cnt_d   = cnt_q;
    retry_d = retry_q;
    nack_d  = nack_q;
    load    = 1'b0;
    finish  = 1'b0;
    err_set = 1'b0;
    pop     = 1'b0;

    if ((state_q == ST_STOP) && sample_tick && cfg_t0 && !line_in) begin
      nack_d = 1'b1;
    end

    if (bit_tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (buf_avail) load = 1'b1;
        end
        ST_START: begin
          state_d = ST_SHIFT;
          idx_d   = 4'd0;
        end
        ST_SHIFT: begin
          if (idx_q == 4'(PARITY_IDX)) state_d = ST_STOP;
          else                         idx_d   = idx_q + 4'd1;
        end
        ST_STOP: begin
          nack_d = 1'b0;
          if (nack_q) begin
            if (retry_q != '0) begin
              retry_d = retry_q - RW'(1);
              cnt_d   = CNTW'(NACK_WAIT_PERIODS);
              state_d = ST_WAIT;
            end else begin
              err_set = 1'b1;
              finish  = 1'b1;
            end
          end else begin
            finish = 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt_q == CNTW'(1)) state_d = ST_START;
          else                   cnt_d   = cnt_q - CNTW'(1);
        end
        ST_GUARD: begin
          if (cnt_q == CNTW'(1)) begin
            if (buf_avail) load    = 1'b1;
            else           state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q - CNTW'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase

      if (finish) begin
        if (cfg_guard != '0) begin
          state_d = ST_GUARD;
          cnt_d   = CNTW'(cfg_guard);
        end else if (buf_avail) begin
          load = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end

      if (load) begin
        pop     = 1'b1;
        state_d = ST_START;
        byte_d  = buf_data;
        par_d   = buf_par;
        retry_d = cfg_retry;
      end
    end

    if (err_set)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= 4'd0;
      byte_q  <= 8'h00;
      par_q   <= 1'b0;
      cnt_q   <= '0;
      retry_q <= '0;
      nack_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      byte_q  <= byte_d;
      par_q   <= par_d;
      cnt_q   <= cnt_d;
      retry_q <= retry_d;
      nack_q  <= nack_d;
      err_q   <= err_d;
    end
  end

  // Line drive decoded from registered state only
  always_comb begin
    unique case (state_q)
      ST_START: tx_oe = 1'b1;
      ST_SHIFT: tx_oe = (idx_q == 4'(PARITY_IDX)) ? ~par_q : ~byte_q[idx_q[2:0]];
      default:  tx_oe = 1'b0;
    endcase
  end

  assign busy     = (state_q == ST_START) || (state_q == ST_SHIFT) ||
                    (state_q == ST_STOP)  || (state_q == ST_WAIT);
  assign err_flag = err_q;

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int unsigned DEPTH   = 2,
  parameter int unsigned GUARD_W = 4,
  parameter int unsigned RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               sample_tick,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic               cfg_t0,
  input  logic               cfg_odd,
  input  logic [GUARD_W-1:0] cfg_guard,
  input  logic [RETRY_W-1:0] cfg_retry,
  input  logic               err_clr,
  input  logic               line_in,
  output logic               tx_oe,
  output logic               busy,
  output logic               buf_full,
  output logic               empty_irq,
  output logic               dma_req,
  output logic               err_flag
);

  logic       rst_sync_n;
  logic       pop;
  logic       avail;
  logic [7:0] head;
  logic       head_par;

  sc_tx_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sc_tx_fifo #(.DW(8), .DEPTH(DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (wr_en),
    .push_data (wr_data),
    .pop       (pop),
    .head      (head),
    .avail     (avail),
    .full      (buf_full),
    .drained   (empty_irq)
  );

  sc_tx_parity #(.W(8)) par_i (
    .din (head),
    .odd (cfg_odd),
    .par (head_par)
  );

  sc_tx_sequencer #(.GW(GUARD_W), .RW(RETRY_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bit_tick    (bit_tick),
    .sample_tick (sample_tick),
    .line_in     (line_in),
    .cfg_t0      (cfg_t0),
    .cfg_guard   (cfg_guard),
    .cfg_retry   (cfg_retry),
    .err_clr     (err_clr),
    .buf_avail   (avail),
    .buf_data    (head),
    .buf_par     (head_par),
    .pop         (pop),
    .tx_oe       (tx_oe),
    .busy        (busy),
    .err_flag    (err_flag)
  );

  assign dma_req = !avail;

endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_oe,
  input logic busy,
  input logic empty_irq,
  input logic dma_req,
  input logic err_flag,
  input logic err_clr
);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_oe);

  // R2
  oe_tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_oe));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_oe);

  // R10
  busy_tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(busy));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  // R11
  irq_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_irq |-> dma_req);

endmodule

bind sc_char_tx sc_char_tx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bit_tick  (bit_tick),
  .tx_oe     (tx_oe),
  .busy      (busy),
  .empty_irq (empty_irq),
  .dma_req   (dma_req),
  .err_flag  (err_flag),
  .err_clr   (err_clr)
);

// File: tb/sc_char_tx_tb.sv
module sc_char_tx_tb_top;

  logic       clk;
  logic       rst_n;
  logic       bit_tick;
  logic       sample_tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       cfg_t0;
  logic       cfg_odd;
  logic [3:0] cfg_guard;
  logic [2:0] cfg_retry;
  logic       err_clr;
  logic       line_in;
  logic       tx_oe;
  logic       busy;
  logic       buf_full;
  logic       empty_irq;
  logic       dma_req;
  logic       err_flag;

  logic nack_drive;

  int n_chk;
  int n_bad;
  bit finished;

  // bit-period phase and receiver model state
  int   phase;
  int   sample_idx;
  int   fpos;
  int   cur_start;
  logic [7:0] acc;
  logic acc_par;
  int   nack_budget;
  bit   clear_pending;
  int   busy_bad;
  int   irq_count;

  int   nframes;
  int   f_start [64];
  logic [7:0] f_byte [64];
  logic f_par [64];
  logic f_stop [64];

  assign line_in = ~(tx_oe | nack_drive);

  sc_char_tx dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .sample_tick (sample_tick),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .cfg_t0      (cfg_t0),
    .cfg_odd     (cfg_odd),
    .cfg_guard   (cfg_guard),
    .cfg_retry   (cfg_retry),
    .err_clr     (err_clr),
    .line_in     (line_in),
    .tx_oe       (tx_oe),
    .busy        (busy),
    .buf_full    (buf_full),
    .empty_irq   (empty_irq),
    .dma_req     (dma_req),
    .err_flag    (err_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Baud strobes, line monitor and receiver error-signal model
  always @(negedge clk) begin
    phase = (phase + 1) % 8;
    bit_tick    <= (phase == 0);
    sample_tick <= (phase == 4);
    if (empty_irq) irq_count++;
    if (phase == 5 && clear_pending) begin
      nack_drive    <= 1'b0;
      clear_pending = 0;
    end
    if (phase == 4 && rst_n) begin
      if (fpos < 0) begin
        if (tx_oe) begin
          fpos = 0;
          cur_start = sample_idx;
          if (!busy) busy_bad++;
        end
      end else begin
        fpos++;
        if (!busy) busy_bad++;
        if (fpos <= 8) acc[fpos-1] = ~tx_oe;
        else if (fpos == 9) begin
          acc_par = ~tx_oe;
          if (nack_budget > 0) begin
            nack_drive <= 1'b1;
            nack_budget--;
          end
        end else begin
          f_start[nframes % 64] = cur_start;
          f_byte[nframes % 64]  = acc;
          f_par[nframes % 64]   = acc_par;
          f_stop[nframes % 64]  = ~tx_oe;
          nframes++;
          clear_pending = 1;
          fpos = -1;
        end
      end
      sample_idx++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic sync_after_tick();
    @(negedge clk);
    while (phase != 1) @(negedge clk);
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 200) begin
      @(negedge clk);
      if (!busy && dma_req && fpos < 0) q++;
      else q = 0;
    end
  endtask

  task automatic check_frame(input string req, input int k, input logic [7:0] b, input logic odd);
    chk({req, " data"}, int'(f_byte[k % 64]), int'(b));
    chk({req, " parity"}, int'(f_par[k % 64]), int'((^b) ^ odd));
    chk({req, " stop released"}, int'(f_stop[k % 64]), 1);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset tx_oe", int'(tx_oe), 0);
    chk("R1 reset dma_req", int'(dma_req), 1);
    chk("R1 reset buf_full", int'(buf_full), 0);
    chk("R1 reset empty_irq", int'(empty_irq), 0);
    chk("R1 reset err_flag", int'(err_flag), 0);
  endtask

  task automatic t_single_even();
    int base = nframes;
    int irq0 = irq_count;
    cfg_t0 = 0; cfg_odd = 0; cfg_guard = 0;
    push_byte(8'hA5);
    chk("R11 dma_req low with data", int'(dma_req), 0);
    wait_quiet();
    chk("R2 frame count", nframes - base, 1);
    check_frame("R2 R3 even", base, 8'hA5, 1'b0);
    chk("R11 one empty pulse", irq_count - irq0, 1);
    chk("R10 busy in frame", busy_bad, 0);
    chk("R1 released after", int'(tx_oe), 0);
  endtask

  task automatic t_single_odd();
    int base = nframes;
    cfg_odd = 1;
    push_byte(8'h3C);
    wait_quiet();
    chk("R3 odd frame count", nframes - base, 1);
    check_frame("R3 odd", base, 8'h3C, 1'b1);
    cfg_odd = 0;
  endtask

  task automatic t_back_to_back();
    int base = nframes;
    int irq0 = irq_count;
    cfg_guard = 0;
    sync_after_tick();
    push_byte(8'h01);
    push_byte(8'h80);
    wait_quiet();
    chk("R4 frame count", nframes - base, 2);
    check_frame("R4 first", base, 8'h01, 1'b0);
    check_frame("R4 second", base + 1, 8'h80, 1'b0);
    chk("R4 start spacing", f_start[(base+1)%64] - f_start[base%64], 11);
    chk("R11 single pulse for burst", irq_count - irq0, 1);
  endtask

  task automatic t_guard();
    int base = nframes;
    cfg_guard = 4'd3;
    sync_after_tick();
    push_byte(8'h55);
    push_byte(8'hAA);
    wait_quiet();
    chk("R5 frame count", nframes - base, 2);
    chk("R5 start spacing", f_start[(base+1)%64] - f_start[base%64], 14);
    check_frame("R5 second", base + 1, 8'hAA, 1'b0);
    chk("R10 busy in frame", busy_bad, 0);
    cfg_guard = 0;
  endtask

  task automatic t_overflow();
    int base = nframes;
    sync_after_tick();
    push_byte(8'h11);
    push_byte(8'h22);
    chk("R6 full after DEPTH writes", int'(buf_full), 1);
    push_byte(8'h33);
    wait_quiet();
    chk("R6 extra write discarded", nframes - base, 2);
    check_frame("R6 first", base, 8'h11, 1'b0);
    check_frame("R6 second", base + 1, 8'h22, 1'b0);
    chk("R6 not full after", int'(buf_full), 0);
  endtask

  task automatic t_nack_once();
    int base = nframes;
    cfg_t0 = 1; cfg_retry = 3'd2; nack_budget = 1;
    push_byte(8'h5A);
    wait_quiet();
    chk("R7 resent once", nframes - base, 2);
    check_frame("R7 original", base, 8'h5A, 1'b0);
    check_frame("R7 resend", base + 1, 8'h5A, 1'b0);
    chk("R7 resend spacing", f_start[(base+1)%64] - f_start[base%64], 13);
    chk("R7 no error", int'(err_flag), 0);
  endtask

  task automatic t_nack_exhaust();
    int base = nframes;
    cfg_t0 = 1; cfg_retry = 3'd1; nack_budget = 2;
    push_byte(8'h96);
    wait_quiet();
    chk("R8 attempts bounded", nframes - base, 2);
    chk("R8 retry spacing", f_start[(base+1)%64] - f_start[base%64], 13);
    chk("R8 error set", int'(err_flag), 1);
    repeat (20) @(negedge clk);
    chk("R8 error sticky", int'(err_flag), 1);
    chk("R8 byte dropped", nframes - base, 2);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    chk("R8 error cleared", int'(err_flag), 0);
    base = nframes;
    push_byte(8'h42);
    wait_quiet();
    chk("R8 next byte once", nframes - base, 1);
    check_frame("R8 next byte", base, 8'h42, 1'b0);
  endtask

  task automatic t_retry_zero();
    int base = nframes;
    cfg_t0 = 1; cfg_retry = 3'd0; nack_budget = 1;
    push_byte(8'hC3);
    wait_quiet();
    chk("R8 zero retry single send", nframes - base, 1);
    chk("R8 zero retry error", int'(err_flag), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_block_mode();
    int base = nframes;
    cfg_t0 = 0; cfg_retry = 3'd3; nack_budget = 1;
    push_byte(8'h7E);
    wait_quiet();
    chk("R9 no resend", nframes - base, 1);
    chk("R9 no error", int'(err_flag), 0);
    chk("R9 budget consumed", nack_budget, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    phase = 0; sample_idx = 0; fpos = -1; nframes = 0; nack_budget = 0;
    clear_pending = 0; busy_bad = 0; irq_count = 0; cur_start = 0;
    acc = 8'h00; acc_par = 1'b0;
    n_chk = 0; n_bad = 0; finished = 0;
    bit_tick = 1'b0; sample_tick = 1'b0; nack_drive = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00; cfg_t0 = 1'b0; cfg_odd = 1'b0;
    cfg_guard = 4'd0; cfg_retry = 3'd0; err_clr = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_even();
    t_single_odd();
    t_back_to_back();
    t_guard();
    t_overflow();
    t_nack_once();
    t_nack_exhaust();
    t_retry_zero();
    t_block_mode();
    finish_run();
  end

endmodule